// File: doc/BRIEF.md
# Secondary Scan Chain Linker

This block is one TAP device in a primary IEEE 1149.1 chain. Through that chain it can splice any subset of four secondary scan chains into the primary serial path, and it can also splice in all four at once. Each secondary chain gets three lines from the block: its own TMS output, a serial data output that feeds the first device on that chain, and a serial data input that takes the output of the last device. Every secondary device is clocked from one shared secondary clock, which follows the primary test clock. The board wires the primary test reset to every device, including those on the secondary chains.

A four-bit path-select register chooses which chains are spliced in. It is written through the block's own TAP. A new selection waits until the primary TAP next enters Run-Test/Idle. A deselected chain has its TMS held low, so its TAPs stay parked in Run-Test/Idle. A newly selected chain has its TMS released only while the primary TAP is in Run-Test/Idle, so every spliced chain stays in step with the primary controller.

The serial order is primary TDI, then the block's own instruction or data register, then the selected secondary chains from index 0 upward, then primary TDO. Each selected chain's data input is captured into a one-bit stage on the rising edge. With a wire loopback from data-out to data-in, each selected chain therefore adds exactly one bit of length.

Top module: `slink_top`

## Requirements
- R1: In Shift-IR and Shift-DR, the serial length from tdi to tdo equals the length of the block's own active register plus one bit for each selected chain whose data-out is looped to its data-in. Selected chains sit after the block's own register, in ascending index order. This holds for all 16 selection codes.
- R2: The instruction register is 2 bits wide and is shifted out LSB first. Capture-IR loads 2'b01, so the first bit out is 1. Code 2'b10 selects the path-select register. Every other code selects the 1-bit bypass register. Reset and Test-Logic-Reset load 2'b11.
- R3: The path-select register is 4 bits wide. Bit i selects chain i, and the register is shifted out LSB first. Capture-DR loads the selection that is currently in force.
- R4: The bypass register is 1 bit wide and captures 0 in Capture-DR.
- R5: A selection written in Update-DR has no effect until the next entry to Run-Test/Idle. If the TAP returns to Select-DR without passing through Run-Test/Idle, a Capture-DR still reads the old selection.
- R6: The TMS output of a deselected chain is held low whatever the primary TMS does.
- R7: The TMS output of a selected chain follows the primary TMS. Its enable is updated on a falling edge of tck.
- R8: In Test-Logic-Reset the selection is cleared to no chains.
- R9: While trstN is low, the selection is cleared, the instruction returns to bypass, every secondary TMS output is 0 and tdoOe is 0. This does not depend on the clock.
- R10: tdo and the secondary data outputs change on the falling edge of tck. tdoOe is 1 only during the half cycles that follow a shift state, and 0 elsewhere.
- R11: The secondary clock output follows tck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Primary test clock |
| trstN | input | 1 | Primary test reset, active low, asynchronous |
| tms | input | 1 | Primary test mode select |
| tdi | input | 1 | Primary serial data in |
| tdo | output | 1 | Primary serial data out, falling-edge timed |
| tdoOe | output | 1 | High while tdo carries shift data |
| secTck | output | 1 | Shared clock for all secondary chains |
| secTms | output | 4 | Per-chain TMS, bit i for chain i |
| secDataOut | output | 4 | Per-chain serial data to the first device on the chain |
| secDataIn | input | 4 | Per-chain serial data from the last device on the chain |

## Verification
The assertions assume that primary TMS and TDI change only after a falling edge of tck and stay stable across the rising edge. They also assume that trstN is held low across at least one rising edge whenever it is asserted. The stimulus drives every input one time unit after a falling edge. It holds reset for several clock cycles. It walks the TAP only through legal TMS sequences, so the per-chain TMS checks always compare values that have settled. The loopback on every chain makes the chain length a pure function of the selection code, and the bench predicts that length with no knowledge of the design's internals.

// File: rtl/slink_pkg.sv
package slink_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  // strobes from the controller to the register datapath
  typedef struct packed {
    logic capIr;
    logic shfIr;
    logic updIr;
    logic capDr;
    logic shfDr;
    logic updDr;
    logic inReset;
    logic toIdle;
  } tapStrobe_t;

  function automatic tapState_e tapNext(input tapState_e s, input logic m);
    tapState_e n;
    case (s)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/slink_tap.sv
module slink_tap
  import slink_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  stateNow,
  output tapStrobe_t strobe
);

  tapState_e stateReg;
  tapState_e stateNxt;

  always_comb stateNxt = tapNext(stateReg, tms);

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stateReg <= ST_TLR;
    else        stateReg <= stateNxt;
  end

  always_comb begin
    strobe.capIr   = (stateReg == ST_CAP_IR);
    strobe.shfIr   = (stateReg == ST_SHF_IR);
    strobe.updIr   = (stateReg == ST_UPD_IR);
    strobe.capDr   = (stateReg == ST_CAP_DR);
    strobe.shfDr   = (stateReg == ST_SHF_DR);
    strobe.updDr   = (stateReg == ST_UPD_DR);
    strobe.inReset = (stateReg == ST_TLR);
    strobe.toIdle  = (stateNxt == ST_RTI) && (stateReg != ST_RTI);
  end

  assign stateNow = stateReg;

endmodule

// File: rtl/slink_regs.sv
module slink_regs
  import slink_pkg::*;
#(
  parameter int NPATH = 4,
  parameter int IR_W  = 2
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  tapStrobe_t       strobe,
  output logic [NPATH-1:0] activeSel,
  output logic             ownOut
);

  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(1);
  localparam logic [IR_W-1:0] IR_SELECT  = IR_W'(2);
  localparam logic [IR_W-1:0] IR_BYPASS  = '1;

  logic [IR_W-1:0]  irShift;
  logic [IR_W-1:0]  irHold;
  logic [NPATH-1:0] selShift;
  logic [NPATH-1:0] selPending;
  logic             bypassBit;
  logic             selInstr;

  assign selInstr = (irHold == IR_SELECT);

  // instruction shift stage, rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            irShift <= IR_CAPTURE;
    else if (strobe.capIr) irShift <= IR_CAPTURE;
    else if (strobe.shfIr) irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // instruction hold stage, falling edge in Update-IR
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)              irHold <= IR_BYPASS;
    else if (strobe.inReset) irHold <= IR_BYPASS;
    else if (strobe.updIr)   irHold <= irShift;
  end

  // path-select shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                        selShift <= '0;
    else if (strobe.capDr && selInstr) selShift <= activeSel;
    else if (strobe.shfDr && selInstr) selShift <= {tdi, selShift[NPATH-1:1]};
  end

  // written selection waits here until the next idle entry
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                        selPending <= '0;
    else if (strobe.inReset)           selPending <= '0;
    else if (strobe.updDr && selInstr) selPending <= selShift;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              activeSel <= '0;
    else if (strobe.inReset) activeSel <= '0;
    else if (strobe.toIdle)  activeSel <= selPending;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                         bypassBit <= 1'b0;
    else if (strobe.capDr && !selInstr) bypassBit <= 1'b0;
    else if (strobe.shfDr && !selInstr) bypassBit <= tdi;
  end

  always_comb begin
    if (strobe.shfIr)  ownOut = irShift[0];
    else if (selInstr) ownOut = selShift[0];
    else               ownOut = bypassBit;
  end

endmodule

// File: rtl/slink_chain.sv
module slink_chain #(
  parameter int NPATH = 4
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             shiftAny,
  input  logic             ownOut,
  input  logic [NPATH-1:0] activeSel,
  input  logic [NPATH-1:0] secDataIn,
  output logic [NPATH-1:0] secDataOut,
  output logic [NPATH-1:0] secTms,
  output logic             tdo,
  output logic             tdoOe
);

  logic [NPATH:0] link;
  assign link[0] = ownOut;

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    logic capBit;
    logic tmsGate;

    always_ff @(posedge tck or negedge trstN) begin
      if (!trstN)        capBit <= 1'b0;
      else if (shiftAny) capBit <= secDataIn[i];
    end

    always_ff @(negedge tck or negedge trstN) begin
      if (!trstN) begin
        secDataOut[i] <= 1'b0;
        tmsGate       <= 1'b0;
      end else begin
        secDataOut[i] <= link[i];
        tmsGate       <= activeSel[i];
      end
    end

    assign link[i+1] = activeSel[i] ? capBit : link[i];
    assign secTms[i] = tms & tmsGate;
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= link[NPATH];
      tdoOe <= shiftAny;
    end
  end

endmodule

// File: rtl/slink_top.sv
module slink_top
  import slink_pkg::*;
#(
  parameter int NPATH = 4,
  parameter int IR_W  = 2
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdoOe,
  output logic             secTck,
  output logic [NPATH-1:0] secTms,
  output logic [NPATH-1:0] secDataOut,
  input  logic [NPATH-1:0] secDataIn
);

  tapState_e        stateNow;
  tapStrobe_t       strobe;
  logic [NPATH-1:0] activeSel;
  logic             ownOut;
  logic             shiftAny;

  assign secTck   = tck;
  assign shiftAny = strobe.shfIr | strobe.shfDr;

  slink_tap u_tap (
    .tck(tck), .trstN(trstN), .tms(tms),
    .stateNow(stateNow), .strobe(strobe)
  );

  slink_regs #(.NPATH(NPATH), .IR_W(IR_W)) u_regs (
    .tck(tck), .trstN(trstN), .tdi(tdi), .strobe(strobe),
    .activeSel(activeSel), .ownOut(ownOut)
  );

  slink_chain #(.NPATH(NPATH)) u_chain (
    .tck(tck), .trstN(trstN), .tms(tms), .shiftAny(shiftAny),
    .ownOut(ownOut), .activeSel(activeSel), .secDataIn(secDataIn),
    .secDataOut(secDataOut), .secTms(secTms), .tdo(tdo), .tdoOe(tdoOe)
  );

endmodule

// File: rtl/slink_chk.sv
module slink_chk
  import slink_pkg::*;
#(
  parameter int NPATH = 4
) (
  input logic             tck,
  input logic             trstN,
  input logic             tms,
  input logic             tdoOe,
  input logic [NPATH-1:0] secTms,
  input logic [NPATH-1:0] activeSel,
  input tapState_e        stateNow
);

  // R6
  desel_tms_low_chk: assert property (@(posedge tck) disable iff (!trstN)
    (secTms & ~activeSel) == '0);

  // R7
  sel_tms_follow_chk: assert property (@(posedge tck) disable iff (!trstN)
    (secTms & activeSel) == ({NPATH{tms}} & activeSel));

  // R5
  sel_change_at_idle_chk: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(activeSel) |-> (stateNow == ST_RTI || stateNow == ST_TLR));

  // R8
  tlr_clears_sel_chk: assert property (@(posedge tck) disable iff (!trstN)
    (stateNow == ST_TLR) |=> (activeSel == '0));

  // R10
  oe_only_shift_chk: assert property (@(posedge tck) disable iff (!trstN)
    tdoOe |-> (stateNow == ST_SHF_DR || stateNow == ST_SHF_IR));

endmodule

bind slink_top slink_chk #(.NPATH(NPATH)) u_chk (
  .tck(tck), .trstN(trstN), .tms(tms), .tdoOe(tdoOe),
  .secTms(secTms), .activeSel(activeSel), .stateNow(stateNow)
);

// File: tb/tb_slink_top.sv
module tb_slink_top;

  localparam int NP = 4;

  logic          tck = 1'b0;
  logic          trstN = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          tdo, tdoOe, secTck;
  logic [NP-1:0] secTms, secDataOut, secDataIn;

  int checks = 0;
  int fails  = 0;

  int    expIdx[$];
  logic  expVal[$];
  string expReq[$];
  bit    shiftMon = 1'b0;
  int    monIdx = 0;

  assign secDataIn = secDataOut;  // loopback on every chain

  always #5 tck = ~tck;

  slink_top dut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoOe(tdoOe), .secTck(secTck),
    .secTms(secTms), .secDataOut(secDataOut), .secDataIn(secDataIn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected bits as the chain produces them
  initial forever begin
    @(negedge tck);
    #2;
    if (shiftMon) begin
      check(tdoOe === 1'b1, "R10", "tdoOe during shift", 32'(tdoOe), 32'd1);
      if (expIdx.size() > 0 && expIdx[0] == monIdx) begin
        check(tdo === expVal[0], expReq[0], $sformatf("tdo bit %0d", monIdx),
              32'(tdo), 32'(expVal[0]));
        void'(expIdx.pop_front());
        void'(expVal.pop_front());
        void'(expReq.pop_front());
      end
      monIdx++;
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
  endtask

  function automatic logic [31:0] mkPat(input int m, input int w, input logic [7:0] v);
    logic [31:0] p = 32'hA5C3_96E1;
    for (int b = 0; b < w; b++) p[m-w+b] = v[b];
    return p;
  endfunction

  // driver: walks to a shift state, pushes the expected bits and shifts; ends in Update
  task automatic scan(input bit isIr, input bit fromSel, input int ownLen,
                      input logic [7:0] capV, input int nSel,
                      input logic [31:0] pat, input int m, input string req);
    if (!fromSel) step(1'b1, 1'b0);
    if (isIr) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int idx = nSel; idx < m; idx++) begin
      int r = idx - nSel;
      expIdx.push_back(idx);
      expVal.push_back(r < ownLen ? capV[r] : pat[r-ownLen]);
      expReq.push_back(req);
    end
    for (int k = 0; k < m; k++) begin
      @(negedge tck);
      #1;
      if (k == 0) begin
        monIdx   = 0;
        shiftMon = 1'b1;
      end
      tms = (k == m - 1);
      tdi = pat[k];
    end
    @(posedge tck);
    #1;
    shiftMon = 1'b0;
    check(expIdx.size() == 0, req, "unconsumed expected bits", 32'(expIdx.size()), 32'd0);
    expIdx.delete();
    expVal.delete();
    expReq.delete();
    step(1'b1, 1'b0);  // Exit1 -> Update
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    fails++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] prev;
    // reset state (R9) and clock forwarding (R11)
    repeat (3) @(negedge tck);
    #1;
    check(secTms == '0, "R9", "secTms in reset", 32'(secTms), 32'd0);
    check(tdoOe == 1'b0, "R9", "tdoOe in reset", 32'(tdoOe), 32'd0);
    @(posedge tck); #1;
    check(secTck == 1'b1, "R11", "secTck high", 32'(secTck), 32'd1);
    @(negedge tck); #1;
    check(secTck == 1'b0, "R11", "secTck low", 32'(secTck), 32'd0);
    trstN = 1'b1;
    step(1'b0, 1'b0);  // -> RTI

    // IR capture 01, length 2, load SELECT (R2)
    scan(1'b1, 1'b0, 2, 8'b01, 0, mkPat(12, 2, 8'b10), 12, "R2 R1");
    step(1'b0, 1'b0);
    @(negedge tck); #2;
    check(tdoOe == 1'b0, "R10", "tdoOe in idle", 32'(tdoOe), 32'd0);

    // write 0101, return to Select-DR without idle: old selection still in force (R5)
    scan(1'b0, 1'b0, 4, 8'h0, 0, mkPat(16, 4, 8'h5), 16, "R3 R1");
    step(1'b1, 1'b0);  // Update -> Select-DR
    scan(1'b0, 1'b1, 4, 8'h0, 0, mkPat(16, 4, 8'h5), 16, "R5");
    step(1'b0, 1'b0);  // -> RTI, selection applied
    @(negedge tck); #1;
    tms = 1'b1;
    #1;
    check(secTms == 4'b0101, "R7 R6", "secTms with tms high", 32'(secTms), 32'h5);
    tms = 1'b0;
    #1;
    check(secTms == 4'b0000, "R7", "secTms with tms low", 32'(secTms), 32'h0);

    // every selection code: readback and chain length (R1 R3)
    prev = 4'b0101;
    for (int c = 0; c < 16; c++) begin
      scan(1'b0, 1'b0, 4, 8'(prev), $countones(prev), mkPat(16, 4, 8'(c)), 16, "R1 R3");
      step(1'b0, 1'b0);
      prev = 4'(c);
    end

    // IR scan through all four chains, load a non-select code (R2)
    scan(1'b1, 1'b0, 2, 8'b01, 4, mkPat(12, 2, 8'b00), 12, "R2 R1");
    step(1'b0, 1'b0);
    // bypass: one bit capturing 0, plus four chain stages (R4)
    scan(1'b0, 1'b0, 1, 8'h0, 4, 32'h1234_5678, 12, "R4 R1");
    step(1'b0, 1'b0);

    // Test-Logic-Reset clears the selection and restores bypass (R8)
    repeat (5) step(1'b1, 1'b0);
    #1;
    check(secTms == '0, "R8", "secTms after TLR", 32'(secTms), 32'd0);
    step(1'b0, 1'b0);
    scan(1'b0, 1'b0, 1, 8'h0, 0, 32'h0F0F_3355, 10, "R8 R4");
    step(1'b0, 1'b0);
    scan(1'b1, 1'b0, 2, 8'b01, 0, mkPat(10, 2, 8'b10), 10, "R2");
    step(1'b0, 1'b0);
    scan(1'b0, 1'b0, 4, 8'h0, 0, mkPat(16, 4, 8'hF), 16, "R8");
    step(1'b0, 1'b0);

    // asynchronous test reset (R9)
    @(negedge tck); #1;
    tms = 1'b1;
    #1;
    check(secTms == 4'b1111, "R7", "all chains follow tms", 32'(secTms), 32'hF);
    trstN = 1'b0;
    #1;
    check(secTms == '0, "R9", "secTms on trst", 32'(secTms), 32'd0);
    check(tdoOe == 1'b0, "R9", "tdoOe on trst", 32'(tdoOe), 32'd0);
    repeat (2) @(negedge tck);
    #1;
    trstN = 1'b1;
    step(1'b0, 1'b0);
    scan(1'b0, 1'b0, 1, 8'h0, 0, 32'h00FF_A5A5, 10, "R9 R4");
    step(1'b0, 1'b0);
    scan(1'b1, 1'b0, 2, 8'b01, 0, mkPat(10, 2, 8'b10), 10, "R9 R2");
    step(1'b0, 1'b0);
    scan(1'b0, 1'b0, 4, 8'h0, 0, mkPat(16, 4, 8'h0), 16, "R9 R3");
    step(1'b0, 1'b0);

    repeat (3) @(negedge tck);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule